// File: doc/BRIEF.md
# Residual Carrier and Sampling Offset Estimator

This block works on the continual pilots of an OFDM receiver after the integer part of the carrier offset has been removed. For every pilot it keeps the complex value from the previous symbol, at the same position in the pilot order. It multiplies the new value by the conjugate of the stored one and adds the product to one of two sums. Pilots on negative carriers go to one sum and pilots on positive carriers go to the other.

When a symbol ends, a single iterative vectoring CORDIC takes the angle of the negative-group sum first and then the angle of the positive-group sum. A common carrier offset turns both groups by the same angle. A sampling clock offset turns them in opposite directions, because its phase grows with the carrier index. The block therefore scales half the sum of the two angles into a carrier-offset estimate and scales their difference into a sampling-offset estimate. Both scale factors are fixed-point parameters, so they can include the symbol-to-guard length ratio, the 1/(2π) normalisation and the mean pilot index.

The estimates go to loop filters outside the block. A one-cycle strobe marks each new pair.

Top module: `rcfo_sco_est`

## Requirements
- R1: While reset is asserted and after it is released, `est_valid` is 0 and `est_cfo` and `est_sco` are 0 until the first estimate.
- R2: The symbol that ends first after reset gives no estimate. Every later symbol end gives one, except in the case of R7.
- R3: A pilot whose `pil_idx` is negative (two's-complement sign bit 1) belongs to the negative group, and a pilot with index zero or positive belongs to the positive group. Order within the symbol does not matter for grouping. Each group sum is Σ z_cur·conj(z_prev), where z_prev is the pilot at the same position in the previous symbol. Pilots must arrive in the same order in every symbol.
- R4: Each group angle is the four-quadrant angle of its sum as a PW-bit two's-complement value, with 2^(PW-1) codes equal to π. It is correct in all four quadrants, including the half-plane where the real part is negative.
- R5: `est_cfo` = ((a_neg + a_pos) · K_CFO) >>> (KF+1), kept to the low OW bits.
- R6: `est_sco` = ((a_pos − a_neg) · K_SCO) >>> KF, kept to the low OW bits.
- R7: A symbol that ends while an estimate is still in progress gives no estimate. Its pilots still become the reference for the next symbol.
- R8: `est_valid` is a one-cycle pulse that rises exactly 2·ITER+4 clock edges after the edge that accepts the last pilot of the symbol. Between pulses, `est_cfo` and `est_sco` hold their values.
- R9: A cycle with `pil_valid` low has no effect on the result, even when it falls inside a symbol.
- R10: The last pilot of one symbol and the first pilot of the next may arrive on consecutive cycles. Both symbols are then processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pil_valid | input | 1 | A pilot sample is present |
| pil_re | input | W | Pilot real part, signed |
| pil_im | input | W | Pilot imaginary part, signed |
| pil_idx | input | IW | Signed carrier index of the pilot |
| pil_last | input | 1 | Marks the last pilot of the symbol |
| est_valid | output | 1 | One-cycle strobe for a new estimate pair |
| est_cfo | output | OW | Signed residual carrier-offset estimate |
| est_sco | output | OW | Signed sampling-offset estimate |

## Verification
Two events can share a clock edge. The correlation stage can restart its sums for the first pilot of a new symbol on the same edge where the controller captures the finished sums of the previous symbol. A symbol end can also arrive while the CORDIC is still busy. The bench provokes both by sending two symbols with no idle cycle between them. It then checks that the estimate for the first symbol matches the pilots it sent, that the second symbol gives no strobe, and that the symbol after a gap is correlated against the dropped symbol's pilots.

// File: rtl/rcfo_pkg.sv
package rcfo_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_NEG  = 2'd1,
    S_POS  = 2'd2
  } est_state_t;
endpackage

// File: rtl/rcfo_pilot_corr.sv
module rcfo_pilot_corr #(
  parameter int W  = 12,
  parameter int NP = 8,
  parameter int IW = 14,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  input  logic signed [IW-1:0] in_idx,
  input  logic                 in_last,
  output logic                 corr_valid,
  output logic signed [AW-1:0] neg_re,
  output logic signed [AW-1:0] neg_im,
  output logic signed [AW-1:0] pos_re,
  output logic signed [AW-1:0] pos_im
);
  localparam int ABW = (NP > 1) ? $clog2(NP) : 1;
  localparam int PRW = 2 * W + 1;

  logic [2*W-1:0] ref_mem [NP];
  logic [2*W-1:0] ref_q;
  logic [ABW-1:0] pos_cnt;
  logic           sym_seen;

  logic                s1_valid, s1_first, s1_last, s1_neg, s1_prev;
  logic signed [W-1:0] s1_re, s1_im;

  // reference store: read-first so one port serves old and new symbol
  always_ff @(posedge clk) begin
    if (in_valid) begin
      ref_q            <= ref_mem[pos_cnt];
      ref_mem[pos_cnt] <= {in_re, in_im};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_cnt  <= '0;
      sym_seen <= 1'b0;
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_neg   <= 1'b0;
      s1_prev  <= 1'b0;
      s1_re    <= '0;
      s1_im    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_first <= (pos_cnt == '0);
        s1_last  <= in_last;
        s1_neg   <= ($signed(in_idx) < 0);
        s1_prev  <= sym_seen;
        s1_re    <= in_re;
        s1_im    <= in_im;
        pos_cnt  <= in_last ? '0 : pos_cnt + 1'b1;
        if (in_last) sym_seen <= 1'b1;
      end
    end
  end

  // current times conjugate of previous: four real products, two adders
  logic signed [W-1:0]   old_re, old_im;
  logic signed [2*W-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [PRW-1:0] prod_re, prod_im;

  always_comb begin
    old_re  = ref_q[2*W-1:W];
    old_im  = ref_q[W-1:0];
    m_rr    = s1_re * old_re;
    m_ii    = s1_im * old_im;
    m_ir    = s1_im * old_re;
    m_ri    = s1_re * old_im;
    prod_re = PRW'(m_rr) + PRW'(m_ii);
    prod_im = PRW'(m_ir) - PRW'(m_ri);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_re     <= '0;
      neg_im     <= '0;
      pos_re     <= '0;
      pos_im     <= '0;
      corr_valid <= 1'b0;
    end else begin
      corr_valid <= s1_valid & s1_last & s1_prev;
      if (s1_valid) begin
        if (s1_neg) begin
          neg_re <= (s1_first ? '0 : neg_re) + AW'(prod_re);
          neg_im <= (s1_first ? '0 : neg_im) + AW'(prod_im);
          if (s1_first) begin
            pos_re <= '0;
            pos_im <= '0;
          end
        end else begin
          pos_re <= (s1_first ? '0 : pos_re) + AW'(prod_re);
          pos_im <= (s1_first ? '0 : pos_im) + AW'(prod_im);
          if (s1_first) begin
            neg_re <= '0;
            neg_im <= '0;
          end
        end
      end
    end
  end

  // R3: a symbol never carries more pilots than the reference store holds
  p_pilot_count_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_last) |-> (32'(pos_cnt) < NP - 1));

  // R2: a finished correlation always has a stored symbol behind it
  p_corr_needs_ref_r2: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> sym_seen);
endmodule

// File: rtl/rcfo_cordic.sv
module rcfo_cordic #(
  parameter int CW   = 30,
  parameter int PW   = 16,
  parameter int ITER = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [CW-1:0] x_in,
  input  logic signed [CW-1:0] y_in,
  output logic                 busy,
  output logic                 done,
  output logic signed [PW-1:0] ang
);
  localparam int IBW = $clog2(ITER + 1);

  logic signed [PW-1:0] atan_tab [ITER];

  generate
    for (genvar g = 0; g < ITER; g++) begin : g_atan
      localparam real STEP = $atan(1.0 / (2.0 ** g));
      localparam int  CODE = $rtoi(STEP / 3.141592653589793 * (2.0 ** (PW - 1)) + 0.5);
      assign atan_tab[g] = PW'(CODE);
    end
  endgenerate

  logic signed [CW-1:0] xr, yr;
  logic signed [PW-1:0] zr;
  logic [IBW-1:0]       it;

  always_ff @(posedge clk) begin
    if (rst) begin
      xr   <= '0;
      yr   <= '0;
      zr   <= '0;
      it   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        it   <= '0;
        if (x_in < 0) begin
          // turn by pi into the right half-plane
          xr <= -x_in;
          yr <= -y_in;
          zr <= {1'b1, {(PW-1){1'b0}}};
        end else begin
          xr <= x_in;
          yr <= y_in;
          zr <= '0;
        end
      end else if (busy) begin
        if (yr >= 0) begin
          xr <= xr + (yr >>> it);
          yr <= yr - (xr >>> it);
          zr <= zr + atan_tab[it];
        end else begin
          xr <= xr - (yr >>> it);
          yr <= yr + (xr >>> it);
          zr <= zr - atan_tab[it];
        end
        it <= it + 1'b1;
        if (it == IBW'(ITER - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign ang = zr;

  // R8: completion is a single-cycle event
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: the result is never flagged while iterations are still running
  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/rcfo_sco_est.sv
module rcfo_sco_est #(
  parameter int W     = 12,
  parameter int NP    = 8,
  parameter int IW    = 14,
  parameter int PW    = 16,
  parameter int ITER  = 11,
  parameter int KW    = 16,
  parameter int KF    = 14,
  parameter int OW    = 18,
  parameter int K_CFO = 13107,
  parameter int K_SCO = 13107
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pil_valid,
  input  logic signed [W-1:0]  pil_re,
  input  logic signed [W-1:0]  pil_im,
  input  logic signed [IW-1:0] pil_idx,
  input  logic                 pil_last,
  output logic                 est_valid,
  output logic signed [OW-1:0] est_cfo,
  output logic signed [OW-1:0] est_sco
);
  import rcfo_pkg::*;

  localparam int AW = 2 * W + 1 + ((NP > 1) ? $clog2(NP) : 1);
  localparam int CW = AW + 2;
  localparam int SW = PW + 1;
  localparam int FW = PW + KW + 1;
  localparam logic signed [KW-1:0] KC = KW'(K_CFO);
  localparam logic signed [KW-1:0] KS = KW'(K_SCO);

  logic                 corr_valid;
  logic signed [AW-1:0] neg_re, neg_im, pos_re, pos_im;

  rcfo_pilot_corr #(.W(W), .NP(NP), .IW(IW), .AW(AW)) u_corr (
    .clk(clk), .rst(rst),
    .in_valid(pil_valid), .in_re(pil_re), .in_im(pil_im),
    .in_idx(pil_idx), .in_last(pil_last),
    .corr_valid(corr_valid),
    .neg_re(neg_re), .neg_im(neg_im), .pos_re(pos_re), .pos_im(pos_im)
  );

  est_state_t           st;
  logic signed [AW-1:0] snap_re, snap_im;
  logic signed [PW-1:0] ang_neg;

  logic                 c_start, c_busy, c_done;
  logic signed [CW-1:0] c_x, c_y;
  logic signed [PW-1:0] c_ang;

  // negative group goes straight in; positive group waits in the snapshot
  always_comb begin
    c_start = ((st == S_IDLE) && corr_valid) || ((st == S_NEG) && c_done);
    c_x     = (st == S_NEG) ? CW'(snap_re) : CW'(neg_re);
    c_y     = (st == S_NEG) ? CW'(snap_im) : CW'(neg_im);
  end

  rcfo_cordic #(.CW(CW), .PW(PW), .ITER(ITER)) u_cordic (
    .clk(clk), .rst(rst), .start(c_start), .x_in(c_x), .y_in(c_y),
    .busy(c_busy), .done(c_done), .ang(c_ang)
  );

  logic signed [SW-1:0] a_sum, a_dif;
  logic signed [FW-1:0] cfo_full, sco_full;

  always_comb begin
    a_sum    = SW'(ang_neg) + SW'(c_ang);
    a_dif    = SW'(c_ang) - SW'(ang_neg);
    cfo_full = FW'(a_sum) * FW'(KC);
    sco_full = FW'(a_dif) * FW'(KS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      snap_re   <= '0;
      snap_im   <= '0;
      ang_neg   <= '0;
      est_valid <= 1'b0;
      est_cfo   <= '0;
      est_sco   <= '0;
    end else begin
      est_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (corr_valid) begin
          snap_re <= pos_re;
          snap_im <= pos_im;
          st      <= S_NEG;
        end
        S_NEG: if (c_done) begin
          ang_neg <= c_ang;
          st      <= S_POS;
        end
        S_POS: if (c_done) begin
          est_cfo   <= OW'(cfo_full >>> (KF + 1));
          est_sco   <= OW'(sco_full >>> KF);
          est_valid <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: the shared CORDIC is only launched when it is free
  p_start_when_free_r7: assert property (@(posedge clk) disable iff (rst)
    c_start |-> !c_busy);

  // R8: the strobe lasts one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    est_valid |=> !est_valid);

  // R8: estimates hold between strobes
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    !est_valid |-> ($stable(est_cfo) && $stable(est_sco)));

  // R7: a symbol end during a running estimate does not restart the sequence
  p_busy_ignores_end_r7: assert property (@(posedge clk) disable iff (rst)
    (corr_valid && st == S_POS) |=> (st != S_NEG));
endmodule

// File: tb/sim_rcfo_sco_est.sv
`timescale 1ns/1ps
module sim_rcfo_sco_est;
  localparam int W = 12, NP = 8, IW = 14, PW = 16, ITER = 11;
  localparam int KW = 16, KF = 14, OW = 18, K_CFO = 13107, K_SCO = 11000;
  localparam int LAT = 2 * ITER + 4;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pil_valid = 1'b0, pil_last = 1'b0;
  logic signed [W-1:0]  pil_re = '0, pil_im = '0;
  logic signed [IW-1:0] pil_idx = '0;
  logic est_valid;
  logic signed [OW-1:0] est_cfo, est_sco;

  always #4 clk = ~clk;

  rcfo_sco_est #(.W(W), .NP(NP), .IW(IW), .PW(PW), .ITER(ITER), .KW(KW), .KF(KF),
                 .OW(OW), .K_CFO(K_CFO), .K_SCO(K_SCO)) u0 (
    .clk(clk), .rst(rst), .pil_valid(pil_valid), .pil_re(pil_re), .pil_im(pil_im),
    .pil_idx(pil_idx), .pil_last(pil_last),
    .est_valid(est_valid), .est_cfo(est_cfo), .est_sco(est_sco));

  int total = 0, bad = 0, n_est = 0, cyc = 0;
  bit finished = 0;
  real q_cfo[$], q_sco[$];
  int  q_cyc[$];
  string q_tag[$];

  int  idx[NP];
  int  prev_re[NP], prev_im[NP];
  real phs[NP];
  bit  have_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input real got, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0f expected=%0f", req, got, exp);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic set_order(input bit interleave);
    for (int p = 0; p < NP; p++) begin
      if (interleave) idx[p] = (p % 2 == 0) ? (5 + 11 * p) : -(3 + 9 * p);
      else            idx[p] = (p < NP / 2) ? -(40 - 9 * p) : (5 + 12 * (p - NP / 2));
      phs[p] = 0.4 * p;
    end
    have_prev = 0;
  endtask

  // drives one symbol; leaves pil_valid high after the last pilot
  task automatic send_sym(input real dn, input real dp, input bit expect_est,
                          input bit gaps, input string tag);
    longint nr = 0, ni = 0, pr = 0, pi = 0;
    int last_cyc = 0;
    int cre[NP], cim[NP];
    for (int p = 0; p < NP; p++) begin
      real amp;
      amp = 600.0 + 40.0 * p;
      phs[p] = phs[p] + ((idx[p] < 0) ? dn : dp) + 0.02 * p;
      cre[p] = $rtoi(amp * $cos(phs[p]));
      cim[p] = $rtoi(amp * $sin(phs[p]));
      if (idx[p] < 0) begin
        nr += longint'(cre[p]) * prev_re[p] + longint'(cim[p]) * prev_im[p];
        ni += longint'(cim[p]) * prev_re[p] - longint'(cre[p]) * prev_im[p];
      end else begin
        pr += longint'(cre[p]) * prev_re[p] + longint'(cim[p]) * prev_im[p];
        pi += longint'(cim[p]) * prev_re[p] - longint'(cre[p]) * prev_im[p];
      end
      @(negedge clk);
      pil_valid = 1'b1;
      pil_re    = W'(cre[p]);
      pil_im    = W'(cim[p]);
      pil_idx   = IW'(idx[p]);
      pil_last  = (p == NP - 1);
      if (p == NP - 1) last_cyc = cyc + 1;
      if (gaps && (p % 2 == 1) && (p != NP - 1)) begin
        @(negedge clk);
        pil_valid = 1'b0;
        pil_re    = '1;
        pil_last  = 1'b1;
      end
    end
    if (expect_est && have_prev) begin
      real an, ap;
      an = $atan2(real'(ni), real'(nr)) / PI * (2.0 ** (PW - 1));
      ap = $atan2(real'(pi), real'(pr)) / PI * (2.0 ** (PW - 1));
      q_cfo.push_back((an + ap) * K_CFO / (2.0 ** (KF + 1)));
      q_sco.push_back((ap - an) * K_SCO / (2.0 ** KF));
      q_cyc.push_back(last_cyc + LAT);
      q_tag.push_back(tag);
    end
    for (int p = 0; p < NP; p++) begin
      prev_re[p] = cre[p];
      prev_im[p] = cim[p];
    end
    have_prev = 1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    pil_valid = 1'b0;
    pil_last  = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pil_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(est_valid == 1'b0 && est_cfo == 0 && est_sco == 0, "R1 reset outputs",
        real'(est_cfo) + real'(est_sco) + real'(est_valid), 0.0);
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && est_valid) begin
      n_est++;
      if (q_cfo.size() == 0) begin
        chk(1'b0, "R2/R7 unexpected estimate", real'(est_cfo), 0.0);
      end else begin
        real ec, es;
        int ecyc;
        string tg;
        ec = q_cfo.pop_front();
        es = q_sco.pop_front();
        ecyc = q_cyc.pop_front();
        tg = q_tag.pop_front();
        chk(rabs(real'(est_cfo) - ec) <= 24.0, {"R5 cfo ", tg}, real'(est_cfo), ec);
        chk(rabs(real'(est_sco) - es) <= 32.0, {"R6 sco ", tg}, real'(est_sco), es);
        chk(cyc == ecyc, {"R8 latency ", tg}, real'(cyc), real'(ecyc));
      end
    end
  end

  initial begin
    #1200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_order(1'b0);
    repeat (5) @(negedge clk);
    chk(est_valid == 1'b0 && est_cfo == 0 && est_sco == 0, "R1 reset outputs",
        real'(est_cfo) + real'(est_sco), 0.0);
    rst = 1'b0;

    send_sym(0.3, 0.5, 1'b1, 1'b0, "R2");
    idle(40);
    chk(n_est == 0, "R2 first symbol silent", real'(n_est), 0.0);

    send_sym(0.3, 0.5, 1'b1, 1'b0, "R3");   idle(40);
    send_sym(-0.7, 0.2, 1'b1, 1'b0, "R3");  idle(40);
    send_sym(2.5, -2.6, 1'b1, 1'b0, "R4");  idle(40);
    send_sym(-2.2, 1.9, 1'b1, 1'b0, "R4");  idle(40);
    send_sym(0.9, -0.4, 1'b1, 1'b1, "R9");  idle(40);

    // back-to-back: first ends an estimate, second lands while busy
    send_sym(0.1, 0.6, 1'b1, 1'b0, "R10");
    send_sym(-1.3, 0.8, 1'b0, 1'b0, "R7");
    idle(60);
    send_sym(-1.0, -0.2, 1'b1, 1'b0, "R7"); idle(40);

    do_reset();
    set_order(1'b1);
    send_sym(0.5, 0.5, 1'b1, 1'b0, "R2");   idle(40);
    send_sym(1.2, -1.5, 1'b1, 1'b0, "R3");  idle(40);
    send_sym(-0.4, 2.2, 1'b1, 1'b1, "R9");  idle(60);

    chk(q_cfo.size() == 0, "R2 missing estimates", real'(q_cfo.size()), 0.0);
    chk(n_est == 9, "R7 estimate count", real'(n_est), 9.0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule